// File: doc/BRIEF.md
# Reset Cause Status Register

This block remembers why the system last came out of reset. It holds one sticky flag for each reset source: the low-power reset, the window watchdog, the independent watchdog, the software reset, the power-on reset and the external pin reset. A reset controller drives a one-cycle event strobe for each source except power-on. The flags sit in an always-on clock domain, so only the power-on reset, which is this block's own synchronous reset, wipes them.

Firmware reads the 32-bit status word through a small valid/ack register port. After reading it, firmware clears all the flags at once by writing 1 to a single write-only command bit. The flag bits themselves can never be written, so software cannot make it look as though a reset happened. If firmware forgets to clear the flags, an old watchdog cause stays visible across every later reset that is not a power-on reset.

Top module: `rst_cause_reg`

## Requirements
- R1: The status word places the flags at fixed positions: bit 31 low-power, bit 30 window watchdog, bit 29 independent watchdog, bit 28 software, bit 27 power-on and bit 26 external pin. Bits 25 down to 0 always read as 0, and this includes the clear bit 24.
- R2: When `por_i` is high at a clock edge, the word becomes exactly 0x0800_0000: the power-on flag is set and every other flag is cleared.
- R3: An event strobe that is high at a clock edge sets its flag at that edge.
- R4: A set flag stays set across any number of cycles and later events, until a clear command or a power-on reset. Flags from different events accumulate.
- R5: A write with bit 24 of `req_wdata_i` set to 1 clears all six flags at the edge where the request is sampled.
- R6: A write never sets or changes a flag through bits 31 to 26. A write with bit 24 set to 0 leaves the word unchanged.
- R7: If an event and a clear command arrive in the same cycle, the event wins, so its flag reads as set and all other flags read as cleared.
- R8: Several event strobes in the same cycle set all of their flags.
- R9: A read (`req_valid_i`=1, `req_write_i`=0) returns on `rsp_rdata_o` one cycle later the flag state from before the request edge. For a write, and in every cycle without a request, `rsp_rdata_o` is 0.
- R10: `rsp_ack_o` is high for exactly the cycle after each cycle with `req_valid_i`=1, and low otherwise. It is low after a power-on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on domain clock |
| por_i | input | 1 | Power-on reset, synchronous, active high |
| lowpwr_evt_i | input | 1 | Low-power reset event strobe |
| wwdg_evt_i | input | 1 | Window watchdog reset event strobe |
| iwdg_evt_i | input | 1 | Independent watchdog reset event strobe |
| soft_evt_i | input | 1 | Software reset event strobe |
| pin_evt_i | input | 1 | External pin reset event strobe |
| req_valid_i | input | 1 | Register access request |
| req_write_i | input | 1 | 1 for a write, 0 for a read |
| req_wdata_i | input | 32 | Write data; only bit 24 has an effect |
| rsp_ack_o | output | 1 | Access completed, one cycle after the request |
| rsp_rdata_o | output | 32 | Read data, 0 when not answering a read |

## Verification
The assertions take each event strobe to be a clean one-cycle level in the always-on clock domain, sampled only at clock edges. They also take the power-on reset to be held high from time zero until the first edge, so no property samples an unset register. The stimulus drives all inputs at the falling edge. It starts with `por_i` already high, and it lets events, clears and power-on resets coincide in any combination, because the precedence between them is defined.

// File: rtl/rcr_pkg.sv
package rcr_pkg;
  parameter int DATA_W   = 32;
  parameter int NSRC     = 6;
  parameter int FLAG_LSB = 26;
  parameter int CLR_BIT  = 24;

  // source index -> word bit FLAG_LSB + index
  typedef enum logic [2:0] {
    SRC_PIN    = 3'd0,
    SRC_POR    = 3'd1,
    SRC_SOFT   = 3'd2,
    SRC_IWDG   = 3'd3,
    SRC_WWDG   = 3'd4,
    SRC_LOWPWR = 3'd5
  } src_e;

  localparam int POR_IDX = int'(SRC_POR);
endpackage

// File: rtl/rcr_flag_bank.sv
module rcr_flag_bank
  import rcr_pkg::*;
#(
  parameter int N_FLAGS = NSRC,
  parameter int POR_SLOT = POR_IDX
) (
  input  logic               clk,
  input  logic               por_i,
  input  logic [N_FLAGS-1:0] evt_i,
  input  logic               clr_i,
  output logic [N_FLAGS-1:0] flags_o
);

  for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (por_i) begin
        flags_o[g] <= (g == POR_SLOT);
      end else if (evt_i[g]) begin
        flags_o[g] <= 1'b1;
      end else if (clr_i) begin
        flags_o[g] <= 1'b0;
      end
    end

    // R4
    sticky_chk: assert property (@(posedge clk) disable iff (por_i)
      (flags_o[g] && !clr_i) |=> flags_o[g]);

    // R3
    evt_sets_chk: assert property (@(posedge clk) disable iff (por_i)
      evt_i[g] |=> flags_o[g]);

    // R5
    clr_chk: assert property (@(posedge clk) disable iff (por_i)
      (clr_i && !evt_i[g]) |=> !flags_o[g]);
  end

  // R2
  por_word_chk: assert property (@(posedge clk)
    por_i |=> (flags_o == N_FLAGS'(1 << POR_SLOT)));

endmodule

// File: rtl/rcr_bus_port.sv
module rcr_bus_port
  import rcr_pkg::*;
#(
  parameter int W      = DATA_W,
  parameter int N_FLAGS = NSRC,
  parameter int LSB    = FLAG_LSB,
  parameter int CBIT   = CLR_BIT
) (
  input  logic               clk,
  input  logic               por_i,
  input  logic [N_FLAGS-1:0] flags_i,
  input  logic               req_valid_i,
  input  logic               req_write_i,
  input  logic [W-1:0]       req_wdata_i,
  output logic               clr_o,
  output logic               rsp_ack_o,
  output logic [W-1:0]       rsp_rdata_o
);

  logic [W-1:0] word;

  always_comb begin
    word = '0;
    word[LSB +: N_FLAGS] = flags_i;
  end

  assign clr_o = req_valid_i && req_write_i && req_wdata_i[CBIT];

  always_ff @(posedge clk) begin
    if (por_i) begin
      rsp_ack_o   <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_ack_o   <= req_valid_i;
      rsp_rdata_o <= (req_valid_i && !req_write_i) ? word : '0;
    end
  end

  // R10
  ack_chk: assert property (@(posedge clk) disable iff (por_i)
    req_valid_i |=> rsp_ack_o);

  // R10
  no_spur_ack_chk: assert property (@(posedge clk) disable iff (por_i)
    !req_valid_i |=> !rsp_ack_o);

  // R1
  reserved_zero_chk: assert property (@(posedge clk) disable iff (por_i)
    rsp_ack_o |-> (rsp_rdata_o[LSB-1:0] == '0));

endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
  import rcr_pkg::*;
(
  input  logic              clk,
  input  logic              por_i,
  input  logic              lowpwr_evt_i,
  input  logic              wwdg_evt_i,
  input  logic              iwdg_evt_i,
  input  logic              soft_evt_i,
  input  logic              pin_evt_i,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_ack_o,
  output logic [DATA_W-1:0] rsp_rdata_o
);

  logic [NSRC-1:0] evt_vec;
  logic [NSRC-1:0] flags;
  logic            clr;

  always_comb begin
    evt_vec             = '0;
    evt_vec[SRC_PIN]    = pin_evt_i;
    evt_vec[SRC_SOFT]   = soft_evt_i;
    evt_vec[SRC_IWDG]   = iwdg_evt_i;
    evt_vec[SRC_WWDG]   = wwdg_evt_i;
    evt_vec[SRC_LOWPWR] = lowpwr_evt_i;
  end

  rcr_flag_bank #(.N_FLAGS(NSRC), .POR_SLOT(POR_IDX)) u_bank (
    .clk     (clk),
    .por_i   (por_i),
    .evt_i   (evt_vec),
    .clr_i   (clr),
    .flags_o (flags)
  );

  rcr_bus_port #(.W(DATA_W), .N_FLAGS(NSRC), .LSB(FLAG_LSB), .CBIT(CLR_BIT)) u_port (
    .clk         (clk),
    .por_i       (por_i),
    .flags_i     (flags),
    .req_valid_i (req_valid_i),
    .req_write_i (req_write_i),
    .req_wdata_i (req_wdata_i),
    .clr_o       (clr),
    .rsp_ack_o   (rsp_ack_o),
    .rsp_rdata_o (rsp_rdata_o)
  );

endmodule

// File: tb/test_rst_cause_reg.sv
module test_rst_cause_reg;
  logic        clk = 1'b0;
  logic        por_i = 1'b1;
  logic [4:0]  ev = '0;   // 0 pin,1 soft,2 iwdg,3 wwdg,4 lowpwr
  logic        req_valid_i = 1'b0;
  logic        req_write_i = 1'b0;
  logic [31:0] req_wdata_i = '0;
  logic        rsp_ack_o;
  logic [31:0] rsp_rdata_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] m_word = 32'h0800_0000;
  logic        m_ack = 1'b0;
  logic [31:0] m_rdata = '0;

  always #10 clk = ~clk;

  rst_cause_reg i_rst_cause_reg (
    .clk(clk), .por_i(por_i),
    .lowpwr_evt_i(ev[4]), .wwdg_evt_i(ev[3]), .iwdg_evt_i(ev[2]),
    .soft_evt_i(ev[1]), .pin_evt_i(ev[0]),
    .req_valid_i(req_valid_i), .req_write_i(req_write_i), .req_wdata_i(req_wdata_i),
    .rsp_ack_o(rsp_ack_o), .rsp_rdata_o(rsp_rdata_o)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive at negedge, advance model, compare at next negedge
  task automatic step(logic p, logic [4:0] e, logic v, logic w, logic [31:0] wd);
    logic [31:0] evb;
    por_i = p; ev = e; req_valid_i = v; req_write_i = w; req_wdata_i = wd;
    evb = {e[4], e[3], e[2], e[1], 1'b0, e[0], 26'd0};
    if (p) begin
      m_ack = 0; m_rdata = 0; m_word = 32'h0800_0000;
    end else begin
      m_ack = v;
      m_rdata = (v && !w) ? m_word : 32'h0;
      m_word = ((v && w && wd[24]) ? 32'h0 : m_word) | evb;
    end
    @(negedge clk);
    check("R10 ack", {31'd0, rsp_ack_o}, {31'd0, m_ack});
    check("R9 rdata", rsp_rdata_o, m_rdata);
  endtask

  task automatic rd(string tag, logic [31:0] exp);
    step(0, 0, 1, 0, 0);
    check(tag, rsp_rdata_o, exp);
  endtask

  initial begin
    @(negedge clk);
    step(1, 0, 0, 0, 0);
    check("R10 reset ack", {31'd0, rsp_ack_o}, 32'd0);
    rd("R2 after power-on", 32'h0800_0000);
    step(0, 5'b00100, 0, 0, 0);
    rd("R3 iwdg set", 32'h2800_0000);
    step(0, 5'b00001, 0, 0, 0);
    repeat (5) step(0, 0, 0, 0, 0);
    rd("R4 sticky accumulate", 32'h2C00_0000);
    check("R1 reserved bits", rsp_rdata_o & 32'h03FF_FFFF, 32'h0);
    step(0, 0, 1, 1, 32'hFEFF_FFFF);
    rd("R6 flag write ignored", 32'h2C00_0000);
    step(0, 0, 1, 1, 32'h0100_0000);
    rd("R5 clear all", 32'h0);
    step(0, 0, 1, 1, 32'hFC00_0000);
    rd("R6 cannot fake cause", 32'h0);
    step(0, 5'b00010, 0, 0, 0);
    step(0, 5'b01000, 1, 1, 32'h0100_0000);
    rd("R7 event beats clear", 32'h4000_0000);
    step(0, 5'b10011, 0, 0, 0);
    rd("R8 simultaneous events", 32'hD400_0000);
    step(1, 5'b11111, 1, 1, 32'h0100_0000);
    rd("R2 power-on wipes", 32'h0800_0000);
    step(0, 0, 1, 1, 32'hFFFF_FFFF);
    check("R9 write rdata zero", rsp_rdata_o, 32'h0);
    for (int i = 0; i < 3000; i++) begin
      logic [4:0] e;
      logic v, w, p;
      logic [31:0] wd;
      e  = ($urandom_range(0, 3) == 0) ? 5'($urandom) : 5'd0;
      v  = $urandom_range(0, 1) == 1;
      w  = $urandom_range(0, 2) == 0;
      wd = $urandom;
      p  = $urandom_range(0, 99) == 0;
      step(p, e, v, w, wd);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule